// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block is a register-level model of the management register set of a 10/100 Ethernet PHY. A host reaches the model through a small 32-bit register port with three locations. The target location holds a PHY address and a register index. A write to the write-data location carries out a PHY register write at that target. A read of the read-data location carries out a PHY register read at that target. Read data appears one clock after the read strobe.

The model holds writable control and advertisement registers. It returns fixed identifier words, which are parameters. The status and link-partner registers follow a link input. A control write with the reset bit set reloads the register set to its reset values and is not stored. An access aimed at a PHY address other than the configured one reads all ones and writes nothing. Serial management signalling, real auto-negotiation and line behaviour are not modelled.

Top module: `mii_mgmt_model`

## Requirements
- R1: After reset, control (index 0) reads 0x3100: speed bit 13, auto-negotiation enable bit 12 and full-duplex bit 8. Advertisement (index 4) reads 0x01E1: bits 8, 7, 6, 5 and selector bit 0.
- R2: Status (index 1) reads 0x7848 while the link is down. While the link is up it reads 0x786C, which adds auto-negotiation-complete (bit 5) and link-status (bit 2).
- R3: Link partner (index 5) reads 0x0080 while the link is down and 0x01E1 while the link is up.
- R4: Index 2 returns parameter `ID_HI` and index 3 returns parameter `ID_LO`.
- R5: When the target PHY address differs from parameter `PHY_ADDR`, a PHY read returns 0x0000FFFF and a PHY write changes no register.
- R6: A PHY write to index 0 with bit 15 set restores control to 0x3100 and advertisement to 0x01E1, and does not store the written value.
- R7: A PHY write to index 0 with bit 15 clear stores bits 15:0 in control. A PHY write to index 4 stores bits 15:0 in advertisement.
- R8: Writes to indices 1, 2, 3, 5, 6 and to every unimplemented index change no register. Every index other than 0 to 5 reads 0.
- R9: Host locations are selected by `bus_sel`: 0 target, 1 write data, 2 read data. The target holds the PHY address in bits 12:8 and the index in bits 4:0. Reading the target returns those fields with all other bits zero. Reading location 1 or 3 returns 0.
- R10: `bus_rdata` is updated on the clock edge that samples `bus_rd`. It holds its value until the next read.
- R11: `link_up` is registered once. A change is visible to PHY reads started one cycle or more later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Line link state, 1 = up |
| bus_sel | input | 2 | Host location select |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, one cycle after `bus_rd` |

## Verification
The embedded properties check the following on every cycle:
- a read aimed at a foreign address returns all ones;
- writes to a foreign address or to read-only indices leave control and advertisement unchanged;
- a soft reset leaves the reset values in place;
- an ordinary control write is stored;
- read data holds between reads.

Link-dependent bits after a link change, the identifier words, target readback and the exact register contents after mixed random sequences are shown only by the bench scenarios. The bench compares each read with a reference model kept in the bench.

// File: rtl/mii_mgmt_model.sv
module mii_mgmt_model #(
  parameter logic [4:0]  PHY_ADDR = 5'd1,
  parameter logic [15:0] ID_HI    = 16'h2A5C,
  parameter logic [15:0] ID_LO    = 16'hB0E1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up,
  input  logic [1:0]  bus_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam logic [1:0]  SEL_TGT  = 2'd0;
  localparam logic [1:0]  SEL_WD   = 2'd1;
  localparam logic [1:0]  SEL_RD   = 2'd2;
  localparam logic [15:0] CTL_INIT = 16'h3100;
  localparam logic [15:0] ADV_INIT = 16'h01E1;
  localparam logic [15:0] STS_BASE = 16'h7848;
  localparam logic [15:0] STS_LINK = 16'h0024;
  localparam logic [15:0] LP_DOWN  = 16'h0080;
  localparam logic [15:0] LP_UP    = 16'h01E1;

  logic [4:0]  tgt_addr, tgt_idx;
  logic [15:0] ctl_q, adv_q;
  logic        link_q;
  logic [15:0] mii_rd;

  wire own    = (tgt_addr == PHY_ADDR);
  wire phy_wr = bus_wr && (bus_sel == SEL_WD) && own;
  wire [15:0] status_w  = STS_BASE | (link_q ? STS_LINK : 16'h0000);
  wire [15:0] partner_w = link_q ? LP_UP : LP_DOWN;

  always_comb begin
    if (!own) mii_rd = 16'hFFFF;
    else begin
      case (tgt_idx)
        5'd0:    mii_rd = ctl_q;
        5'd1:    mii_rd = status_w;
        5'd2:    mii_rd = ID_HI;
        5'd3:    mii_rd = ID_LO;
        5'd4:    mii_rd = adv_q;
        5'd5:    mii_rd = partner_w;
        default: mii_rd = 16'h0000;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_addr <= '0;
      tgt_idx  <= '0;
      ctl_q    <= CTL_INIT;
      adv_q    <= ADV_INIT;
      link_q   <= 1'b0;
    end else begin
      link_q <= link_up;
      if (bus_wr && bus_sel == SEL_TGT) begin
        tgt_addr <= bus_wdata[12:8];
        tgt_idx  <= bus_wdata[4:0];
      end
      if (phy_wr && tgt_idx == 5'd0) begin
        if (bus_wdata[15]) begin
          ctl_q <= CTL_INIT;
          adv_q <= ADV_INIT;
        end else begin
          ctl_q <= bus_wdata[15:0];
        end
      end
      if (phy_wr && tgt_idx == 5'd4) adv_q <= bus_wdata[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_sel)
        SEL_TGT: bus_rdata <= {19'd0, tgt_addr, 3'd0, tgt_idx};
        SEL_RD:  bus_rdata <= {16'd0, mii_rd};
        default: bus_rdata <= '0;
      endcase
    end
  end

  p_foreign_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_sel == SEL_RD && tgt_addr != PHY_ADDR |=> bus_rdata == 32'h0000FFFF);

  p_foreign_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_sel == SEL_WD && tgt_addr != PHY_ADDR |=> $stable(ctl_q) && $stable(adv_q));

  p_soft_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phy_wr && tgt_idx == 5'd0 && bus_wdata[15] |=> ctl_q == CTL_INIT && adv_q == ADV_INIT);

  p_ctl_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phy_wr && tgt_idx == 5'd0 && !bus_wdata[15] |=> ctl_q == $past(bus_wdata[15:0]));

  p_readonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phy_wr && tgt_idx != 5'd0 && tgt_idx != 5'd4 |=> $stable(ctl_q) && $stable(adv_q));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd && rst_n |=> $stable(bus_rdata));

  p_status_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_sel == SEL_RD && own && tgt_idx == 5'd1 |=> bus_rdata[5] == bus_rdata[2]);
endmodule

// File: tb/test_mii_mgmt_model.sv
module test_mii_mgmt_model;
  localparam logic [4:0]  OWN_A = 5'd1;
  localparam logic [15:0] IDH = 16'h2A5C;
  localparam logic [15:0] IDL = 16'hB0E1;

  logic clk = 0, rst_n = 0, link_up = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_sel = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  int checks = 0, errors = 0;
  logic [15:0] m_ctl, m_adv;
  logic [4:0] m_addr, m_idx;
  logic m_link;
  bit done = 0;

  always #2.5 clk = ~clk;

  mii_mgmt_model #(.PHY_ADDR(OWN_A), .ID_HI(IDH), .ID_LO(IDL)) i_mii_mgmt_model (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic logic [31:0] exp_phy();
    if (m_addr != OWN_A) return 32'h0000FFFF;
    case (m_idx)
      5'd0: return {16'd0, m_ctl};
      5'd1: return {16'd0, m_link ? 16'h786C : 16'h7848};
      5'd2: return {16'd0, IDH};
      5'd3: return {16'd0, IDL};
      5'd4: return {16'd0, m_adv};
      5'd5: return {16'd0, m_link ? 16'h01E1 : 16'h0080};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); bus_sel = s; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    if (s == 2'd0) begin m_addr = d[12:8]; m_idx = d[4:0]; end
    if (s == 2'd1 && m_addr == OWN_A) begin
      if (m_idx == 5'd0) begin
        if (d[15]) begin m_ctl = 16'h3100; m_adv = 16'h01E1; end
        else m_ctl = d[15:0];
      end else if (m_idx == 5'd4) m_adv = d[15:0];
    end
  endtask

  task automatic hread(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); bus_sel = s; bus_rd = 1;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  task automatic phy_rd(input logic [4:0] a, input logic [4:0] i, input string req);
    logic [31:0] v;
    hwrite(2'd0, {19'd0, a, 3'd0, i});
    hread(2'd2, v);
    check(req, v, exp_phy());
  endtask

  task automatic phy_wr(input logic [4:0] a, input logic [4:0] i, input logic [31:0] d);
    hwrite(2'd0, {19'd0, a, 3'd0, i});
    hwrite(2'd1, d);
  endtask

  task automatic set_link(input logic l);
    @(negedge clk); link_up = l; m_link = l;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, held;
    void'($urandom(32'd1234));
    m_ctl = 16'h3100; m_adv = 16'h01E1; m_addr = 0; m_idx = 0; m_link = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R10 reset rdata", bus_rdata, 32'd0);
    phy_rd(OWN_A, 5'd0, "R1 control reset");
    phy_rd(OWN_A, 5'd4, "R1 advert reset");
    phy_rd(OWN_A, 5'd1, "R2 status link down");
    phy_rd(OWN_A, 5'd5, "R3 partner link down");
    phy_rd(OWN_A, 5'd2, "R4 id high");
    phy_rd(OWN_A, 5'd3, "R4 id low");
    set_link(1);
    phy_rd(OWN_A, 5'd1, "R11 R2 status link up");
    phy_rd(OWN_A, 5'd5, "R3 partner link up");
    phy_rd(5'd7, 5'd0, "R5 foreign read");
    phy_wr(5'd7, 5'd0, 32'h0000_0000);
    phy_wr(5'd7, 5'd4, 32'h0000_0001);
    phy_rd(OWN_A, 5'd0, "R5 foreign write ignored ctl");
    phy_rd(OWN_A, 5'd4, "R5 foreign write ignored adv");
    phy_wr(OWN_A, 5'd0, 32'hFFFF_1234);
    phy_rd(OWN_A, 5'd0, "R7 control store");
    phy_wr(OWN_A, 5'd4, 32'h0000_0061);
    phy_rd(OWN_A, 5'd4, "R7 advert store");
    phy_wr(OWN_A, 5'd0, 32'h0000_8000);
    phy_rd(OWN_A, 5'd0, "R6 soft reset ctl");
    phy_rd(OWN_A, 5'd4, "R6 soft reset adv");
    phy_rd(OWN_A, 5'd1, "R6 status keeps link");
    phy_wr(OWN_A, 5'd1, 32'h0); phy_wr(OWN_A, 5'd5, 32'h0); phy_wr(OWN_A, 5'd6, 32'h0);
    phy_rd(OWN_A, 5'd1, "R8 status read-only");
    phy_rd(OWN_A, 5'd5, "R8 partner read-only");
    phy_rd(OWN_A, 5'd6, "R8 expansion zero");
    phy_rd(OWN_A, 5'd17, "R8 vendor zero");
    phy_rd(OWN_A, 5'd0, "R8 ctl untouched");
    hwrite(2'd0, 32'hFFFF_FFFF);
    hread(2'd0, v);
    check("R9 target readback", v, 32'h0000_1F1F);
    hread(2'd1, v);
    check("R9 wdata loc zero", v, 32'd0);
    hread(2'd3, v);
    check("R9 loc3 zero", v, 32'd0);
    phy_rd(OWN_A, 5'd2, "R10 read");
    held = bus_rdata;
    repeat (4) @(negedge clk);
    check("R10 hold", bus_rdata, held);
    set_link(0);
    phy_rd(OWN_A, 5'd1, "R11 link drop");
    for (int n = 0; n < 1500; n++) begin
      logic [4:0] a, i;
      int op;
      a = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31)) : OWN_A;
      i = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31)) : 5'($urandom_range(0, 6));
      op = $urandom_range(0, 9);
      if (op < 4) phy_rd(a, i, "R1 R7 random read");
      else if (op < 8) phy_wr(a, i, ($urandom_range(0, 7) == 0) ? $urandom() | 32'h8000 : $urandom() & 32'hFFFF7FFF);
      else set_link(1'($urandom_range(0, 1)));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule